// File: doc/BRIEF.md
# Four-Mode Addressable Bit Latch

This block keeps an eight-bit output word in which any single bit can be loaded from one serial data input. A three-bit address selects which bit receives the data. Two active-low control lines, an enable and a clear, choose one of four modes:

- **write**: the addressed bit is loaded and the other bits keep their values.
- **hold**: every bit keeps its value.
- **demultiplex**: the addressed bit is loaded and every other bit is driven low, so the word acts as a one-of-eight router for the data bit.
- **clear**: the whole word is driven to zero.

Every mode takes effect on the rising clock edge. While the enable stays low, the addressed bit therefore tracks the data input once per cycle. A separate asynchronous active-low reset empties the word at power-up.

The mode is a named enumerated value (`MODE_WRITE`, `MODE_HOLD`, `MODE_DEMUX`, `MODE_CLEAR`). It is decoded from the two control lines on every cycle, so any mode can follow any other directly. The transitions of interest are these:

- write to hold freezes the word.
- hold to write resumes loading.
- any mode to demultiplex or to clear discards the unaddressed bits.
- reset returns the word to zero from every mode.

Top module: `addressable_bit_latch`

## Requirements
- R1: Address value k (binary, 0..7) selects output bit `q[k]`, and only that bit, for loading.
- R2: With `wr_en_n`=0 and `clr_n`=1 (write), the edge loads `q[addr]` with `din` and leaves all other bits unchanged.
- R3: With `wr_en_n`=0 and `clr_n`=0 (demultiplex), the edge loads `q[addr]` with `din` and drives every other bit to 0.
- R4: With `wr_en_n`=1 and `clr_n`=1 (hold), the edge leaves all bits unchanged whatever `din` and `addr` are.
- R5: With `wr_en_n`=1 and `clr_n`=0 (clear), the edge drives all eight bits to 0.
- R6: `rst_n` low clears all bits at once, without waiting for a clock edge, and no load happens while it is low.
- R7: In write mode, moving the address from one bit to another leaves every earlier written bit at its last written value.
- R8: Outputs change only at the rising clock edge; input changes between edges do not affect `q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every mode is applied on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears the word |
| addr | input | 3 | Bit select, binary |
| din | input | 1 | Data bit loaded into the selected position |
| wr_en_n | input | 1 | Active-low enable for loading |
| clr_n | input | 1 | Active-low clear control |
| q | output | 8 | Parallel output word |

## Verification
The asynchronous reset and a pending load can fall in the same cycle. The bench pulls `rst_n` low between edges while write mode is set up with a data bit of 1, and checks that the word reads zero at once and stays zero across the edge while reset is held. It then releases reset and checks that the load lands only on the first edge after release. A second collision is a mode change that coincides with a new address and data value on the same edge. The bench checks it by comparing every cycle against its own next-state model as the sweep steps through all four modes at every address.

// File: rtl/abl_pkg.sv
package abl_pkg;
    typedef enum logic [1:0] {
        MODE_WRITE = 2'd0,
        MODE_HOLD  = 2'd1,
        MODE_DEMUX = 2'd2,
        MODE_CLEAR = 2'd3
    } abl_mode_e;
endpackage

// File: rtl/abl_mode_dec.sv
module abl_mode_dec
    import abl_pkg::*;
(
    input  logic      wr_en_n,
    input  logic      clr_n,
    output abl_mode_e mode
);
    always_comb begin
        unique case ({wr_en_n, clr_n})
            2'b01:   mode = MODE_WRITE;
            2'b00:   mode = MODE_DEMUX;
            2'b11:   mode = MODE_HOLD;
            default: mode = MODE_CLEAR;
        endcase
    end
endmodule

// File: rtl/abl_addr_dec.sv
module abl_addr_dec #(
    parameter int ADDR_W = 3,
    localparam int NBITS = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NBITS-1:0]  sel
);
    for (genvar i = 0; i < NBITS; i++) begin : g_dec
        assign sel[i] = (addr == ADDR_W'(i));
    end

    // R1: a known address selects exactly one bit
    always_comb begin
        if (!$isunknown(addr)) begin
            assert_one_select_R1: assert ($countones(sel) == 1)
                else $error("decoder select not one-hot");
        end
    end
endmodule

// File: rtl/abl_bit_cell.sv
module abl_bit_cell
    import abl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  abl_mode_e mode,
    input  logic      sel,
    input  logic      din,
    output logic      q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            unique case (mode)
                MODE_WRITE: if (sel) q <= din;
                MODE_DEMUX: q <= sel ? din : 1'b0;
                MODE_HOLD:  q <= q;
                MODE_CLEAR: q <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/addressable_bit_latch.sv
module addressable_bit_latch
    import abl_pkg::*;
#(
    parameter int ADDR_W = 3,
    localparam int NBITS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    input  logic              wr_en_n,
    input  logic              clr_n,
    output logic [NBITS-1:0]  q
);
    abl_mode_e        mode;
    logic [NBITS-1:0] sel;

    abl_mode_dec u_mode (
        .wr_en_n (wr_en_n),
        .clr_n   (clr_n),
        .mode    (mode)
    );

    abl_addr_dec #(.ADDR_W(ADDR_W)) u_addr (
        .addr (addr),
        .sel  (sel)
    );

    for (genvar i = 0; i < NBITS; i++) begin : g_cell
        abl_bit_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (mode),
            .sel   (sel[i]),
            .din   (din),
            .q     (q[i])
        );
    end

    assert_write_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_n && clr_n) |=> q[$past(addr)] == $past(din))
        else $error("write did not load addressed bit");

    assert_write_others_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_n && clr_n) |=>
            ((q & ~(NBITS'(1) << $past(addr))) == ($past(q) & ~(NBITS'(1) << $past(addr)))))
        else $error("write disturbed unaddressed bits");

    assert_demux_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_n && !clr_n) |=> q == (NBITS'($past(din)) << $past(addr)))
        else $error("demultiplex word wrong");

    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_n && clr_n) |=> $stable(q))
        else $error("hold changed the word");

    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_n && !clr_n) |=> q == '0)
        else $error("clear left bits set");
endmodule

// File: tb/addressable_bit_latch_tb_top.sv
`timescale 1ns/1ps
module addressable_bit_latch_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] addr;
    logic       din;
    logic       wr_en_n;
    logic       clr_n;
    logic [7:0] q;
    logic [7:0] model;
    int         n_checks = 0;
    int         n_errors = 0;

    always #5 clk = ~clk;

    addressable_bit_latch dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .din     (din),
        .wr_en_n (wr_en_n),
        .clr_n   (clr_n),
        .q       (q)
    );

    function automatic logic [7:0] next_word(logic [7:0] cur, logic en_n, logic cl_n,
                                             logic [2:0] a, logic d);
        logic [7:0] r;
        r = cur;
        if (!en_n && cl_n)       r[a] = d;
        else if (!en_n && !cl_n) begin r = 8'h00; r[a] = d; end
        else if (en_n && !cl_n)  r = 8'h00;
        return r;
    endfunction

    task automatic check(string req, logic [7:0] exp);
        n_checks++;
        if (q !== exp) begin
            n_errors++;
            $display("FAIL %s: q=%h expected=%h", req, q, exp);
        end
    endtask

    // drive at negedge, apply one edge, compare at the following negedge
    task automatic step(string req, logic en_n, logic cl_n, logic [2:0] a, logic d);
        wr_en_n = en_n; clr_n = cl_n; addr = a; din = d;
        @(posedge clk);
        model = next_word(model, en_n, cl_n, a, d);
        @(negedge clk);
        check(req, model);
    endtask

    task automatic t_reset_collision;
        step("R2", 1'b0, 1'b1, 3'd2, 1'b1);
        wr_en_n = 1'b0; clr_n = 1'b1; addr = 3'd5; din = 1'b1;
        #1 rst_n = 1'b0; model = 8'h00;
        #1 check("R6", 8'h00);
        @(negedge clk);
        check("R6", 8'h00);
        rst_n = 1'b1;
        step("R6", 1'b0, 1'b1, 3'd5, 1'b1);
    endtask

    task automatic t_write_walk;
        for (int k = 0; k < 8; k++) begin
            step("R1", 1'b0, 1'b1, 3'(k), 1'b1);
            check("R1", 8'((1 << (k + 1)) - 1) | 8'h20);
        end
        step("R2", 1'b0, 1'b1, 3'd3, 1'b0);
        check("R2", 8'hF7);
    endtask

    task automatic t_addr_move;
        step("R5", 1'b1, 1'b0, 3'd0, 1'b0);
        step("R7", 1'b0, 1'b1, 3'd1, 1'b1);
        step("R7", 1'b0, 1'b1, 3'd6, 1'b1);
        step("R7", 1'b0, 1'b1, 3'd4, 1'b0);
        check("R7", 8'h42);
    endtask

    task automatic t_between_edges;
        step("R2", 1'b0, 1'b1, 3'd0, 1'b1);
        wr_en_n = 1'b1; clr_n = 1'b0;
        #2 check("R8", model);
        wr_en_n = 1'b0; clr_n = 1'b0; addr = 3'd7; din = 1'b1;
        #2 check("R8", model);
        step("R4", 1'b1, 1'b1, 3'd2, 1'b1);
    endtask

    task automatic t_hold;
        logic [7:0] snap;
        snap = model;
        for (int k = 0; k < 8; k++) step("R4", 1'b1, 1'b1, 3'(k), 1'(k & 1));
        check("R4", snap);
    endtask

    task automatic t_demux_walk;
        for (int k = 0; k < 8; k++) begin
            step("R3", 1'b0, 1'b0, 3'(k), 1'b1);
            check("R3", 8'(1 << k));
        end
        step("R3", 1'b0, 1'b0, 3'd4, 1'b0);
        check("R3", 8'h00);
    endtask

    task automatic t_clear;
        step("R2", 1'b0, 1'b1, 3'd6, 1'b1);
        step("R5", 1'b1, 1'b0, 3'd6, 1'b1);
        check("R5", 8'h00);
    endtask

    task automatic t_sweep;
        string tag [4] = '{"R2", "R3", "R4", "R5"};
        logic  en_v [4] = '{1'b0, 1'b0, 1'b1, 1'b1};
        logic  cl_v [4] = '{1'b1, 1'b0, 1'b1, 1'b0};
        for (int m = 0; m < 4; m++)
            for (int k = 0; k < 8; k++) begin
                step(tag[m], 1'b0, 1'b1, 3'(7 - k), 1'b1);
                step(tag[m], en_v[m], cl_v[m], 3'(k), 1'((k + m) & 1));
            end
    endtask

    initial begin
        #1_000_000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: q=%h expected=done", q);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en_n = 1'b1; clr_n = 1'b1; addr = '0; din = 1'b0;
        model = 8'h00;
        @(negedge clk);
        check("R6", 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_collision();
        t_write_walk();
        t_addr_move();
        t_between_edges();
        t_hold();
        t_demux_walk();
        t_clear();
        t_sweep();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule